// File: doc/BRIEF.md
# Circular Framebuffer Stream Reader

This block reads a rectangular picture out of memory and presents it as a pixel stream for a video output path. Software sets up the picture through a small write-only register port. The settings are the address of the top-left pixel, the byte distance between the starts of two lines, the number of bytes in each line and the number of lines. The block then fetches the picture one pixel at a time over a request/response memory port. Each pixel leaves on a valid/ready stream. The first pixel of a picture is flagged on `pix_tuser` and the last pixel of every line on `pix_tlast`.

Two control bits decide what happens. A run bit permits a transfer, and a loop bit makes the reader start the same picture again each time it finishes. Setting the run bit alone does not start anything. Writing a non-zero line count does. Geometry is copied into the address generator only when a picture begins. Software can therefore point the reader at a second buffer while the current picture is still streaming. It rewrites the address and the line count, and the swap happens on a picture boundary.

Stream rules: a pixel is transferred on a clock edge where `pix_tvalid` and `pix_tready` are both high. Once `pix_tvalid` is raised, it stays high, and data and flags stay unchanged, until that transfer happens. A slow sink only stretches the picture in time. No pixel is dropped or repeated. Memory requests follow the same hold rule on `mem_req_valid`/`mem_req_ready`. Each request is answered by one `mem_rsp_valid` pulse.

Top module: `fbr_stream_reader`

## Requirements
- R1: After reset, `halted` is 1 and both `pix_tvalid` and `mem_req_valid` are 0.
- R2: Register select 0 is control: bit 0 is run, bit 1 is loop. Writing the line count while run is 0 starts nothing.
- R3: With run set and a non-zero line size held, a non-zero write to select 4 (line count) starts a picture. The picture delivers (line bytes / 2) × line count pixels.
- R4: Pixel k of line r is read from base + r·stride + 2k (select 1 base, select 2 stride, select 3 line bytes). Bit 0 of the base and the stride is ignored.
- R5: Stream pixels carry the memory response data in the order the addresses were issued.
- R6: `pix_tuser` is 1 only on the first pixel of each picture. `pix_tlast` is 1 only on the last pixel of each line.
- R7: With loop clear, `halted` returns to 1 after the last pixel of the picture is accepted. While `halted` is 1, neither valid output is raised.
- R8: With loop set, the picture restarts without a gap in control. A new base takes effect only at the next picture boundary, never inside a picture.
- R9: Clearing run while a picture streams stops the block after the line in progress has been fully delivered.
- R10: A line count write of 0, or a line-bytes write below 2, is ignored. The register keeps its old value and no picture starts.
- R11: While `pix_tvalid` is high and `pix_tready` low, `pix_tvalid`, `pix_tdata`, `pix_tuser` and `pix_tlast` hold.
- R12: At most one memory read is outstanding. While `mem_req_valid` is high and `mem_req_ready` low, the request and its address hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0 control, 1 base, 2 stride, 3 line bytes, 4 line count |
| cfg_wdata | input | 32 | Register write data |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the pixel to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | PIX_W | Read data |
| pix_tvalid | output | 1 | Stream pixel valid |
| pix_tready | input | 1 | Stream sink ready |
| pix_tdata | output | PIX_W | Pixel value |
| pix_tuser | output | 1 | First pixel of a picture |
| pix_tlast | output | 1 | Last pixel of a line |
| halted | output | 1 | Reader idle |

## Verification
A wrong line or column counter shows up as a wrong address. A stream tag then appears on the wrong beat. Both are visible on the next pixel: `pix_tlast` lands off its line end, or the data no longer matches the expected address. A corrupted state machine either sticks, which leaves `halted` low past a picture's length, or stops early, which leaves a short beat count. A base register that is sampled too late or too early gives a picture whose pixels come from two buffers. The bench compares every beat of each picture against one buffer at a time, so that mixing is caught within that picture.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
  localparam int FBR_AW   = 32;
  localparam int FBR_GW   = 16;
  localparam int FBR_SELW = 3;

  typedef enum logic [FBR_SELW-1:0] {
    SEL_CTRL   = 3'd0,
    SEL_BASE   = 3'd1,
    SEL_STRIDE = 3'd2,
    SEL_HBYTES = 3'd3,
    SEL_LINES  = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic [FBR_AW-1:0] base;
    logic [FBR_AW-1:0] stride;
    logic [FBR_GW-1:0] hbytes;
    logic [FBR_GW-1:0] lines;
  } frame_geo_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_SEND
  } rd_state_e;
endpackage

// File: rtl/fbr_cfg_regs.sv
module fbr_cfg_regs
  import fbr_pkg::*;
#(
  parameter int PIX_BYTES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [FBR_SELW-1:0] wr_sel,
  input  logic [FBR_AW-1:0]   wr_data,
  output logic                run,
  output logic                loop_en,
  output frame_geo_t          geo,
  output logic                launch
);
  localparam logic [FBR_AW-1:0] MASK_A = ~FBR_AW'(PIX_BYTES - 1);
  localparam logic [FBR_GW-1:0] MASK_G = ~FBR_GW'(PIX_BYTES - 1);

  logic [FBR_GW-1:0] hb_aligned;
  assign hb_aligned = wr_data[FBR_GW-1:0] & MASK_G;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      loop_en <= 1'b0;
      geo     <= '0;
      launch  <= 1'b0;
    end else begin
      launch <= 1'b0;
      if (wr_en) begin
        case (reg_sel_e'(wr_sel))
          SEL_CTRL: begin
            run     <= wr_data[0];
            loop_en <= wr_data[1];
          end
          SEL_BASE:   geo.base   <= wr_data & MASK_A;
          SEL_STRIDE: geo.stride <= wr_data & MASK_A;
          SEL_HBYTES: begin
            if (hb_aligned != '0) geo.hbytes <= hb_aligned;
          end
          SEL_LINES: begin
            if (wr_data[FBR_GW-1:0] != '0) begin
              geo.lines <= wr_data[FBR_GW-1:0];
              launch    <= run && (geo.hbytes != '0);
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/fbr_addr_gen.sv
module fbr_addr_gen
  import fbr_pkg::*;
#(
  parameter int PIX_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  frame_geo_t        geo_in,
  input  logic              step,
  output logic [FBR_AW-1:0] addr,
  output logic              first_pix,
  output logic              end_line,
  output logic              end_frame
);
  localparam logic [FBR_GW:0] COL_STEP = (FBR_GW + 1)'(PIX_BYTES);

  logic [FBR_AW-1:0] line_base_q, stride_q;
  logic [FBR_GW-1:0] hbytes_q, lines_q, col_q, row_q;
  logic [FBR_GW:0]   col_next;

  assign col_next  = {1'b0, col_q} + COL_STEP;
  assign end_line  = (col_next == {1'b0, hbytes_q});
  assign end_frame = end_line && (row_q == (lines_q - FBR_GW'(1)));
  assign first_pix = (col_q == '0) && (row_q == '0);
  assign addr      = line_base_q + FBR_AW'(col_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_base_q <= '0;
      stride_q    <= '0;
      hbytes_q    <= '0;
      lines_q     <= '0;
      col_q       <= '0;
      row_q       <= '0;
    end else if (load) begin
      line_base_q <= geo_in.base;
      stride_q    <= geo_in.stride;
      hbytes_q    <= geo_in.hbytes;
      lines_q     <= geo_in.lines;
      col_q       <= '0;
      row_q       <= '0;
    end else if (step) begin
      if (end_line) begin
        col_q       <= '0;
        row_q       <= row_q + FBR_GW'(1);
        line_base_q <= line_base_q + stride_q;
      end else begin
        col_q <= col_next[FBR_GW-1:0];
      end
    end
  end
endmodule

// File: rtl/fbr_stream_reader.sv
module fbr_stream_reader
  import fbr_pkg::*;
#(
  parameter int PIX_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [FBR_SELW-1:0] cfg_sel,
  input  logic [FBR_AW-1:0]   cfg_wdata,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [FBR_AW-1:0]   mem_req_addr,
  input  logic                mem_rsp_valid,
  input  logic [PIX_W-1:0]    mem_rsp_data,
  output logic                pix_tvalid,
  input  logic                pix_tready,
  output logic [PIX_W-1:0]    pix_tdata,
  output logic                pix_tuser,
  output logic                pix_tlast,
  output logic                halted
);
  localparam int PIX_BYTES = PIX_W / 8;

  logic       run, loop_en, launch;
  frame_geo_t geo;
  logic       ag_load, ag_step, first_pix, end_line, end_frame;
  rd_state_e  state_q, state_d;

  fbr_cfg_regs #(.PIX_BYTES(PIX_BYTES)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_sel  (cfg_sel),
    .wr_data (cfg_wdata),
    .run     (run),
    .loop_en (loop_en),
    .geo     (geo),
    .launch  (launch)
  );

  fbr_addr_gen #(.PIX_BYTES(PIX_BYTES)) u_agen (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ag_load),
    .geo_in    (geo),
    .step      (ag_step),
    .addr      (mem_req_addr),
    .first_pix (first_pix),
    .end_line  (end_line),
    .end_frame (end_frame)
  );

  always_comb begin
    state_d = state_q;
    ag_load = 1'b0;
    ag_step = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (launch) begin
          ag_load = 1'b1;
          state_d = ST_REQ;
        end
      end
      ST_REQ:  if (mem_req_ready) state_d = ST_WAIT;
      ST_WAIT: if (mem_rsp_valid) state_d = ST_SEND;
      ST_SEND: begin
        if (pix_tready) begin
          if (end_frame) begin
            if (run && loop_en) begin
              ag_load = 1'b1;
              state_d = ST_REQ;
            end else begin
              state_d = ST_IDLE;
            end
          end else if (end_line && !run) begin
            state_d = ST_IDLE;
          end else begin
            ag_step = 1'b1;
            state_d = ST_REQ;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      pix_tdata <= '0;
      pix_tuser <= 1'b0;
      pix_tlast <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_WAIT && mem_rsp_valid) begin
        pix_tdata <= mem_rsp_data;
        pix_tuser <= first_pix;
        pix_tlast <= end_line;
      end
    end
  end

  assign mem_req_valid = (state_q == ST_REQ);
  assign pix_tvalid    = (state_q == ST_SEND);
  assign halted        = (state_q == ST_IDLE);
endmodule

// File: rtl/fbr_stream_reader_chk.sv
module fbr_stream_reader_chk #(
  parameter int PIX_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [31:0]      mem_req_addr,
  input logic             pix_tvalid,
  input logic             pix_tready,
  input logic [PIX_W-1:0] pix_tdata,
  input logic             pix_tuser,
  input logic             pix_tlast,
  input logic             halted
);
  localparam logic [31:0] LOW_MASK = 32'(PIX_W / 8 - 1);

  AST_TVALID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    pix_tvalid && !pix_tready |=> pix_tvalid); // R11
  AST_BEAT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_tvalid && !pix_tready |=> $stable(pix_tdata) && $stable(pix_tuser) && $stable(pix_tlast)); // R11
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R12
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !pix_tvalid); // R12
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !pix_tvalid && !mem_req_valid); // R7
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr & LOW_MASK) == 32'd0); // R4
endmodule

bind fbr_stream_reader fbr_stream_reader_chk #(.PIX_W(PIX_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .pix_tvalid    (pix_tvalid),
  .pix_tready    (pix_tready),
  .pix_tdata     (pix_tdata),
  .pix_tuser     (pix_tuser),
  .pix_tlast     (pix_tlast),
  .halted        (halted)
);

// File: tb/test_fbr_stream_reader.sv
module test_fbr_stream_reader;
  localparam int PIX_W = 16;
  localparam int CAP = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = 3'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic        mem_req_valid, mem_rsp_valid = 1'b0, mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr;
  logic [15:0] mem_rsp_data = 16'd0;
  logic        pix_tvalid, pix_tready = 1'b1, pix_tuser, pix_tlast, halted;
  logic [15:0] pix_tdata;

  int checks = 0, errors = 0, mode = 0;
  int cap_n = 0, hold_err = 0, req_err = 0;
  logic [15:0] cap_d [CAP];
  logic        cap_u [CAP];
  logic        cap_l [CAP];
  logic        prev_stall = 1'b0, prev_rstall = 1'b0;
  logic [17:0] prev_beat = '0;
  logic [31:0] prev_addr = '0;

  always #5 clk = ~clk;

  fbr_stream_reader #(.PIX_W(PIX_W)) i_fbr_stream_reader (.*);

  function automatic logic [15:0] pix_of(logic [31:0] a);
    return a[16:1] ^ 16'h5A3C;
  endfunction

  // memory model: one-cycle response to each accepted request
  always @(posedge clk) begin
    mem_rsp_valid <= mem_req_valid && mem_req_ready;
    mem_rsp_data  <= pix_of(mem_req_addr);
  end

  // sink and memory ready patterns
  always @(negedge clk) begin
    pix_tready    = (mode == 1) ? ~pix_tready : 1'b1;
    mem_req_ready = (mode == 2) ? ~mem_req_ready : 1'b1;
  end

  // beat capture and hold monitors
  always @(posedge clk) begin
    if (rst_n) begin
      if (prev_stall && (!pix_tvalid || {pix_tdata, pix_tuser, pix_tlast} != prev_beat))
        hold_err <= hold_err + 1;
      if (prev_rstall && (!mem_req_valid || mem_req_addr != prev_addr))
        req_err <= req_err + 1;
      if (pix_tvalid && pix_tready) begin
        if (cap_n < CAP) begin
          cap_d[cap_n] <= pix_tdata;
          cap_u[cap_n] <= pix_tuser;
          cap_l[cap_n] <= pix_tlast;
        end
        cap_n <= cap_n + 1;
      end
    end
    prev_stall  <= rst_n && pix_tvalid && !pix_tready;
    prev_beat   <= {pix_tdata, pix_tuser, pix_tlast};
    prev_rstall <= rst_n && mem_req_valid && !mem_req_ready;
    prev_addr   <= mem_req_addr;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    int t;
    ok = 1'b0;
    t = 0;
    while (halted && t < 100) begin @(negedge clk); t++; end
    t = 0;
    while (!halted && t < 5000) begin @(negedge clk); t++; end
    ok = halted;
  endtask

  // base, stride, line bytes, lines, ready mode
  localparam logic [31:0] VT [4][5] = '{
    '{32'h0000_0100, 32'd8,  32'd8, 32'd3, 32'd0},
    '{32'h0000_2000, 32'd16, 32'd6, 32'd2, 32'd1},
    '{32'h0000_0031, 32'd5,  32'd4, 32'd4, 32'd2},
    '{32'h0000_4000, 32'd4,  32'd2, 32'd5, 32'd1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit ok;
    int mark, n, bad, badu, first_a, first_e, t;
    logic [31:0] eb, es, ea;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(halted && !pix_tvalid && !mem_req_valid, "R1", "reset idle",
        {halted, pix_tvalid, mem_req_valid}, 3'b100);

    // table of one-shot pictures
    for (int v = 0; v < 4; v++) begin
      mode = int'(VT[v][4]);
      mark = cap_n;
      wr(3'd0, 32'd1);
      wr(3'd1, VT[v][0]);
      wr(3'd2, VT[v][1]);
      wr(3'd3, VT[v][2]);
      wr(3'd4, VT[v][3]);
      wait_done(ok);
      chk(ok, "R7", "one-shot picture halts", int'(halted), 1);
      n = cap_n - mark;
      chk(n == int'(VT[v][2] / 2 * VT[v][3]), "R3", "beat count", n, int'(VT[v][2] / 2 * VT[v][3]));
      eb = VT[v][0] & ~32'd1;
      es = VT[v][1] & ~32'd1;
      bad = 0; badu = 0; first_a = 0; first_e = 0;
      for (int r = 0; r < int'(VT[v][3]); r++) begin
        for (int k = 0; k < int'(VT[v][2] / 2); k++) begin
          int idx;
          idx = mark + r * int'(VT[v][2] / 2) + k;
          ea = eb + 32'(r) * es + 32'(2 * k);
          if (cap_d[idx] != pix_of(ea)) begin
            if (bad == 0) begin first_a = int'(cap_d[idx]); first_e = int'(pix_of(ea)); end
            bad++;
          end
          if (cap_u[idx] != (r == 0 && k == 0) || cap_l[idx] != (k == int'(VT[v][2] / 2) - 1))
            badu++;
        end
      end
      chk(bad == 0, "R4 R5", "pixel data by address", first_a, first_e);
      chk(badu == 0, "R6", "tuser/tlast placement", badu, 0);
    end
    mode = 0;
    chk(hold_err == 0, "R11", "stream beat held under back-pressure", hold_err, 0);
    chk(req_err == 0, "R12", "memory request held until accepted", req_err, 0);

    // R2 run clear: line count write starts nothing
    mark = cap_n;
    wr(3'd0, 32'd0);
    wr(3'd3, 32'd4);
    wr(3'd1, 32'h700);
    wr(3'd2, 32'd4);
    wr(3'd4, 32'd2);
    repeat (30) @(negedge clk);
    chk(halted && cap_n == mark, "R2", "no launch with run clear", cap_n - mark, 0);

    // R10 zero writes ignored
    wr(3'd0, 32'd1);
    wr(3'd4, 32'd0);
    repeat (30) @(negedge clk);
    chk(halted && cap_n == mark, "R10", "zero line count ignored", cap_n - mark, 0);
    wr(3'd3, 32'd0);
    wr(3'd3, 32'd1);
    wr(3'd1, 32'h600);
    wr(3'd4, 32'd1);
    wait_done(ok);
    chk(cap_n - mark == 2, "R10", "line bytes kept at 4", cap_n - mark, 2);
    chk(cap_d[mark] == pix_of(32'h600) && cap_d[mark + 1] == pix_of(32'h602), "R10",
        "pixels of kept geometry", int'(cap_d[mark + 1]), int'(pix_of(32'h602)));

    // R8 / R9 looping picture, base swap, stop at line end
    mark = cap_n;
    wr(3'd0, 32'd3);
    wr(3'd1, 32'h500);
    wr(3'd2, 32'd4);
    wr(3'd3, 32'd4);
    wr(3'd4, 32'd2);
    t = 0;
    while (cap_n - mark < 6 && t < 2000) begin @(negedge clk); t++; end
    wr(3'd1, 32'h900);
    wr(3'd4, 32'd2);
    t = 0;
    while (cap_n - mark < 14 && t < 2000) begin @(negedge clk); t++; end
    wr(3'd0, 32'd0);
    t = 0;
    while (!halted && t < 500) begin @(negedge clk); t++; end
    n = cap_n - mark;
    chk(n == 16, "R9", "stop after the line in progress", n, 16);
    chk(n > 0 && cap_l[mark + n - 1], "R9", "last beat ends a line", n, 16);
    bad = 0; badu = 0; first_a = 0; first_e = 0;
    for (int i = 0; i < n && i < 32; i++) begin
      ea = ((i < 8) ? 32'h500 : 32'h900) + 32'(2 * (i % 4));
      if (cap_d[mark + i] != pix_of(ea)) begin
        if (bad == 0) begin first_a = int'(cap_d[mark + i]); first_e = int'(pix_of(ea)); end
        bad++;
      end
      if (cap_u[mark + i] != (i % 4 == 0) || cap_l[mark + i] != (i % 2 == 1)) badu++;
    end
    chk(bad == 0, "R8", "base swaps only on picture boundary", first_a, first_e);
    chk(badu == 0, "R6", "tags repeat each looped picture", badu, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule